// File: doc/BRIEF.md
# Time-constant leaky integrate-and-fire neuron

This core advances one fixed-point neuron in discrete time. Each pulse on `step` marks one simulation tick. On a tick the membrane potential moves toward a leak level by a fraction of the remaining distance. That fraction is dt/tau, and it arrives as a signed fixed-point gain, so the potential relaxes exponentially with a programmable time constant.

When the updated potential reaches the firing level, three things happen on that tick. The core raises a one-cycle spike, loads the potential with a programmable restart value, and starts a refractory count. While the count runs, ticks are used up without any integration.

A host layer sets the parameters on plain register inputs. It reads back `v_mem` and watches `spike`. Setting the leak level above the firing level makes the neuron fire on its own, with no synaptic drive. With a refractory length of zero the core behaves as a plain leaky neuron.

Top module: `lif_neuron_core`

## Requirements
- R1: An active-low asynchronous `rst_n` clears `v_mem` to 0 and `spike` to 0, and ends any refractory interval, so the first tick after reset integrates.
- R2: On an integrating tick the new value is V + floor((v_leak − V) · k_step / 2^K_FRAC). Here `k_step` is signed two's complement with K_FRAC fractional bits (default 14, so 16384 means 1.0), and the difference and product are kept at full precision before the arithmetic right shift.
- R3: The updated value saturates at the signed limits of V_W bits (32767 and −32768 by default) instead of wrapping.
- R4: In a cycle without `step`, `v_mem` and the refractory count keep their values and `spike` stays low, even if the parameter inputs change.
- R5: A tick fires when the updated value is greater than or equal to `v_thresh`, compared as signed numbers. `spike` is then high for exactly the one cycle following the clock edge that sampled `step`.
- R6: On a firing tick, `v_mem` takes `v_reset` instead of the updated value.
- R7: With `ref_len` = N > 0, the N ticks after a firing tick are frozen: `v_mem` is unchanged and no spike occurs. Tick N+1 integrates again. This holds for every N up to 2^REF_W − 1.
- R8: With `ref_len` = 0, no tick is frozen, so consecutive ticks may each fire.
- R9: With constant inputs, `v_leak` above `v_thresh` and no other drive, the core fires repeatedly. With a restart value that reaches threshold in one tick, the firing period is `ref_len` + 1 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step | input | 1 | One-cycle simulation tick strobe |
| v_leak | input | V_W | Leak reversal level, signed |
| v_thresh | input | V_W | Firing level, signed |
| v_reset | input | V_W | Restart value loaded on a spike, signed |
| k_step | input | K_W | dt/tau gain, signed, K_FRAC fractional bits |
| ref_len | input | REF_W | Number of frozen ticks after a spike |
| spike | output | 1 | Spike pulse, one cycle |
| v_mem | output | V_W | Membrane potential, signed |

## Verification
The hardest state to reach from the ports is the boundary between the last frozen tick and the first integrating tick. A wrong count there still produces plausible spikes. The stimulus makes this visible by choosing a restart value from which a single integrating tick crosses threshold again. Any tick that integrates too early then shows up as an extra spike, and a late tick shows up as a missing one.

Runs of 3, 4 and 5 ticks with a length of 3 probe that boundary. A full sweep with the largest length, 255, checks the far end of the counter. Positive saturation is reached only by pairing an overshooting gain (about 1.9) with a threshold at the top of the range, where a wrapped sum would fall below threshold and miss the spike.

// File: rtl/lif_pkg.sv
package lif_pkg;

   // Phase of the neuron: integrating normally, or frozen after a spike.
   typedef enum logic {
      PH_INTEG  = 1'b0,
      PH_REFRAC = 1'b1
   } lif_phase_e;

   // Library defaults shared by the modules of the core.
   localparam int unsigned LIF_V_W    = 16;
   localparam int unsigned LIF_K_W    = 16;
   localparam int unsigned LIF_K_FRAC = 14;
   localparam int unsigned LIF_REF_W  = 8;

endpackage

// File: rtl/lif_euler_step.sv
// Forward-Euler relaxation toward the leak level with saturating result.
module lif_euler_step #(
   parameter int unsigned V_W    = lif_pkg::LIF_V_W,
   parameter int unsigned K_W    = lif_pkg::LIF_K_W,
   parameter int unsigned K_FRAC = lif_pkg::LIF_K_FRAC
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic signed [V_W-1:0] v_cur,
   input  logic signed [V_W-1:0] v_leak,
   input  logic signed [K_W-1:0] k_step,
   output logic signed [V_W-1:0] v_next
);

   localparam int unsigned DW = V_W + 1;   // width of the difference
   localparam int unsigned PW = DW + K_W;  // width of the full product
   localparam int unsigned HW = PW - V_W + 1; // bits that must agree to fit

   generate
      if (K_FRAC >= K_W) begin : g_bad_frac
         $error("lif_euler_step: K_FRAC must be below K_W");
      end
      if (V_W < 4) begin : g_bad_vw
         $error("lif_euler_step: V_W must be at least 4");
      end
   endgenerate

   logic signed [DW-1:0] diff;
   logic signed [PW-1:0] diff_x;
   logic signed [PW-1:0] gain_x;
   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] delta;
   logic signed [PW-1:0] sum;
   logic        [HW-1:0] upper;
   logic                 fits;

   assign diff   = $signed({v_leak[V_W-1], v_leak}) - $signed({v_cur[V_W-1], v_cur});
   assign diff_x = $signed({{K_W{diff[DW-1]}}, diff});
   assign gain_x = $signed({{DW{k_step[K_W-1]}}, k_step});
   assign prod   = diff_x * gain_x;
   assign delta  = prod >>> K_FRAC;
   assign sum    = delta + $signed({{(PW-V_W){v_cur[V_W-1]}}, v_cur});

   assign upper  = sum[PW-1:V_W-1];
   assign fits   = (&upper) | ~(|upper);

   always_comb begin
      if (fits) begin
         v_next = sum[V_W-1:0];
      end else if (sum[PW-1]) begin
         v_next = {1'b1, {(V_W-1){1'b0}}};
      end else begin
         v_next = {1'b0, {(V_W-1){1'b1}}};
      end
   end

   // A non-negative increment never lowers the potential (no wrap, R3).
   assert_no_wrap_up_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (delta >= 0) |-> (v_next >= v_cur));
   // A negative increment never raises the potential (no wrap, R3).
   assert_no_wrap_down_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (delta < 0) |-> (v_next <= v_cur));

endmodule

// File: rtl/lif_refractory.sv
// Refractory tick counter; the disabled variant makes a plain leaky neuron.
module lif_refractory
   import lif_pkg::*;
#(
   parameter int unsigned REF_W  = lif_pkg::LIF_REF_W,
   parameter bit          REF_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             fire,
   input  logic [REF_W-1:0] ref_len,
   output lif_phase_e       phase
);

   generate
      if (REF_W < 1) begin : g_bad_refw
         $error("lif_refractory: REF_W must be at least 1");
      end

      if (REF_EN) begin : g_count
         logic [REF_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (step) begin
               if (fire) begin
                  cnt_q <= ref_len;
               end else if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
         end

         assign phase = (cnt_q != '0) ? PH_REFRAC : PH_INTEG;

         // Each frozen tick uses up exactly one count (R7).
         assert_count_down_R7 : assert property (@(posedge clk) disable iff (!rst_n)
            (step && !fire && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
         // A firing tick arms the counter with the programmed length (R7).
         assert_count_load_R7 : assert property (@(posedge clk) disable iff (!rst_n)
            (step && fire) |=> (cnt_q == $past(ref_len)));
         // Without a tick the count is held (R4).
         assert_count_hold_R4 : assert property (@(posedge clk) disable iff (!rst_n)
            !step |=> $stable(cnt_q));
      end else begin : g_plain
         logic unused_ref;
         assign unused_ref = ^{clk, rst_n, step, fire, ref_len};
         assign phase      = PH_INTEG;
      end
   endgenerate

endmodule

// File: rtl/lif_membrane.sv
// Membrane register, threshold decision and spike pulse.
module lif_membrane
   import lif_pkg::*;
#(
   parameter int unsigned V_W = lif_pkg::LIF_V_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  step,
   input  lif_phase_e            phase,
   input  logic signed [V_W-1:0] v_next,
   input  logic signed [V_W-1:0] v_thresh,
   input  logic signed [V_W-1:0] v_reset,
   output logic                  fire,
   output logic signed [V_W-1:0] v_q,
   output logic                  spike_q
);

   logic integrating;

   assign integrating = step && (phase == PH_INTEG);
   assign fire        = integrating && (v_next >= v_thresh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q     <= '0;
         spike_q <= 1'b0;
      end else begin
         spike_q <= fire;
         if (integrating) begin
            v_q <= fire ? v_reset : v_next;
         end
      end
   end

   // No tick: potential held and no spike (R4).
   assert_idle_hold_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> ($stable(v_q) && !spike_q));
   // Frozen tick: potential held and no spike (R7).
   assert_frozen_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (step && phase == PH_REFRAC) |=> ($stable(v_q) && !spike_q));
   // A spike always carries the restart value (R6).
   assert_spike_restart_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spike_q) |-> (v_q == $past(v_reset)));
   // A spike follows only a tick (R5).
   assert_spike_on_tick_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      spike_q |-> $past(step));

endmodule

// File: rtl/lif_neuron_core.sv
// Time-stepped leaky integrate-and-fire neuron with refractory freeze.
module lif_neuron_core
   import lif_pkg::*;
#(
   parameter int unsigned V_W    = lif_pkg::LIF_V_W,
   parameter int unsigned K_W    = lif_pkg::LIF_K_W,
   parameter int unsigned K_FRAC = lif_pkg::LIF_K_FRAC,
   parameter int unsigned REF_W  = lif_pkg::LIF_REF_W,
   parameter bit          REF_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  step,
   input  logic signed [V_W-1:0] v_leak,
   input  logic signed [V_W-1:0] v_thresh,
   input  logic signed [V_W-1:0] v_reset,
   input  logic signed [K_W-1:0] k_step,
   input  logic [REF_W-1:0]      ref_len,
   output logic                  spike,
   output logic signed [V_W-1:0] v_mem
);

   generate
      if (K_W < 2) begin : g_bad_kw
         $error("lif_neuron_core: K_W must be at least 2");
      end
   endgenerate

   logic signed [V_W-1:0] v_cur;
   logic signed [V_W-1:0] v_next;
   logic                  fire;
   lif_phase_e            phase;

   lif_euler_step #(
      .V_W    (V_W),
      .K_W    (K_W),
      .K_FRAC (K_FRAC)
   ) u_euler (
      .clk    (clk),
      .rst_n  (rst_n),
      .v_cur  (v_cur),
      .v_leak (v_leak),
      .k_step (k_step),
      .v_next (v_next)
   );

   lif_refractory #(
      .REF_W  (REF_W),
      .REF_EN (REF_EN)
   ) u_refrac (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .fire    (fire),
      .ref_len (ref_len),
      .phase   (phase)
   );

   lif_membrane #(
      .V_W (V_W)
   ) u_membrane (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .phase    (phase),
      .v_next   (v_next),
      .v_thresh (v_thresh),
      .v_reset  (v_reset),
      .fire     (fire),
      .v_q      (v_cur),
      .spike_q  (spike)
   );

   assign v_mem = v_cur;

endmodule

// File: tb/lif_neuron_core_bench.sv
module lif_neuron_core_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NV         = 18;

   typedef struct packed {
      logic signed [15:0] leak;
      logic signed [15:0] thr;
      logic signed [15:0] rstv;
      logic signed [15:0] gain;
      logic [7:0]         rlen;
      logic [7:0]         nstep;
      logic signed [15:0] exp_v;
      logic [7:0]         exp_spk;
      logic [7:0]         req;
   } vec_t;

   // leak, threshold, restart, gain (1.0 = 16384), ref_len, ticks, expected v, expected spikes, requirement
   localparam vec_t VECS [NV] = '{
      '{16'sd1024,   16'sd30000, 16'sd0,    16'sd8192,  8'd0, 8'd1, 16'sd512,    8'd0, 8'd2}, // R2 one tick
      '{16'sd1024,   16'sd30000, 16'sd0,    16'sd8192,  8'd0, 8'd3, 16'sd896,    8'd0, 8'd2}, // R2 decay
      '{-16'sd1024,  16'sd30000, 16'sd0,    16'sd8192,  8'd0, 8'd2, -16'sd768,   8'd0, 8'd2}, // R2 negative
      '{16'sd3,      16'sd30000, 16'sd0,    16'sd8192,  8'd0, 8'd1, 16'sd1,      8'd0, 8'd2}, // R2 floor +
      '{-16'sd3,     16'sd30000, 16'sd0,    16'sd8192,  8'd0, 8'd1, -16'sd2,     8'd0, 8'd2}, // R2 floor -
      '{16'sd5000,   16'sd30000, 16'sd0,    16'sd16384, 8'd0, 8'd1, 16'sd5000,   8'd0, 8'd2}, // R2 gain 1.0
      '{16'sd5000,   16'sd30000, 16'sd0,    16'sd0,     8'd0, 8'd4, 16'sd0,      8'd0, 8'd2}, // R2 gain 0
      '{-16'sd30000, 16'sd30000, 16'sd0,    16'sd31130, 8'd0, 8'd1, -16'sd32768, 8'd0, 8'd3}, // R3 low clamp
      '{16'sd30000,  16'sd32767, 16'sd100,  16'sd31130, 8'd0, 8'd1, 16'sd100,    8'd1, 8'd3}, // R3 high clamp fires
      '{16'sd2000,   16'sd1000,  -16'sd50,  16'sd8192,  8'd0, 8'd1, -16'sd50,    8'd1, 8'd5}, // R5 R6 equal fires
      '{16'sd2000,   16'sd1001,  -16'sd50,  16'sd8192,  8'd0, 8'd1, 16'sd1000,   8'd0, 8'd5}, // R5 just below
      '{16'sd100,    -16'sd500,  -16'sd1000,16'sd16384, 8'd0, 8'd1, -16'sd1000,  8'd1, 8'd5}, // R5 signed compare
      '{16'sd2000,   16'sd1000,  16'sd0,    16'sd8192,  8'd0, 8'd6, 16'sd0,      8'd6, 8'd8}, // R8 every tick
      '{16'sd2000,   16'sd1000,  16'sd0,    16'sd8192,  8'd2, 8'd6, 16'sd0,      8'd2, 8'd7}, // R7 length 2
      '{16'sd2000,   16'sd1000,  16'sd200,  16'sd8192,  8'd3, 8'd3, 16'sd200,    8'd1, 8'd7}, // R7 frozen
      '{16'sd2000,   16'sd1000,  16'sd200,  16'sd8192,  8'd3, 8'd4, 16'sd200,    8'd1, 8'd7}, // R7 last frozen
      '{16'sd2000,   16'sd1000,  16'sd200,  16'sd8192,  8'd3, 8'd5, 16'sd200,    8'd2, 8'd7}, // R7 resumes
      '{16'sd1500,   16'sd1200,  16'sd0,    16'sd16384, 8'd1, 8'd5, 16'sd0,      8'd3, 8'd9}  // R9 tonic
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               step = 1'b0;
   logic signed [15:0] v_leak = '0;
   logic signed [15:0] v_thresh = '0;
   logic signed [15:0] v_reset = '0;
   logic signed [15:0] k_step = '0;
   logic [7:0]         ref_len = '0;
   logic               spike;
   logic signed [15:0] v_mem;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lif_neuron_core u_lif_neuron_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .v_leak   (v_leak),
      .v_thresh (v_thresh),
      .v_reset  (v_reset),
      .k_step   (k_step),
      .ref_len  (ref_len),
      .spike    (spike),
      .v_mem    (v_mem)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      step  = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic set_params(input vec_t v);
      v_leak   = v.leak;
      v_thresh = v.thr;
      v_reset  = v.rstv;
      k_step   = v.gain;
      ref_len  = v.rlen;
   endtask

   // One tick; returns the spike seen in the cycle after the sampling edge.
   task automatic do_step(output bit s);
      @(negedge clk);
      step = 1'b1;
      @(negedge clk);
      step = 1'b0;
      s = spike;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      bit s;
      int cnt;
      vec_t v;

      // R1: reset state
      do_reset();
      @(negedge clk);
      check(v_mem == 16'sd0, "R1", "v_mem after reset", int'(v_mem), 0);
      check(spike == 1'b0, "R1", "spike after reset", int'(spike), 0);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         v = VECS[i];
         do_reset();
         set_params(v);
         cnt = 0;
         for (int t = 0; t < int'(v.nstep); t++) begin
            do_step(s);
            if (s) cnt++;
         end
         @(negedge clk);
         check(v_mem == v.exp_v, $sformatf("R%0d", v.req),
               $sformatf("vector %0d v_mem", i), int'(v_mem), int'(v.exp_v));
         check(cnt == int'(v.exp_spk), $sformatf("R%0d", v.req),
               $sformatf("vector %0d spike count", i), cnt, int'(v.exp_spk));
      end

      // R4: parameter changes without a tick have no effect
      do_reset();
      set_params(VECS[0]);
      do_step(s);
      do_step(s);
      v_leak   = -16'sd20000;
      k_step   = 16'sd16384;
      v_thresh = -16'sd30000;
      cnt = 0;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         if (spike) cnt++;
      end
      check(v_mem == 16'sd768, "R4", "v_mem held without tick", int'(v_mem), 768);
      check(cnt == 0, "R4", "spikes without tick", cnt, 0);

      // R5: spike pulse lasts one cycle
      do_reset();
      set_params(VECS[9]);
      do_step(s);
      check(s == 1'b1, "R5", "spike after firing tick", int'(s), 1);
      @(negedge clk);
      check(spike == 1'b0, "R5", "spike one cycle later", int'(spike), 0);

      // R1: reset ends a refractory interval
      do_reset();
      set_params(VECS[12]);
      ref_len = 8'd5;
      do_step(s);
      do_reset();
      do_step(s);
      check(s == 1'b1, "R1", "first tick after reset fires", int'(s), 1);

      // R7: longest refractory length, 255 frozen ticks
      do_reset();
      set_params(VECS[14]);
      ref_len = 8'd255;
      cnt = 0;
      for (int t = 0; t < 256; t++) begin
         do_step(s);
         if (s) cnt++;
      end
      check(cnt == 1, "R7", "spikes during 255 frozen ticks", cnt, 1);
      check(v_mem == 16'sd200, "R7", "v_mem frozen at restart", int'(v_mem), 200);
      do_step(s);
      check(s == 1'b1, "R7", "tick 256 after spike fires", int'(s), 1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule